// File: doc/BRIEF.md
# Split-Cache Unified-Memory Arbiter

This block sits between a processor core's two buses (one for instruction fetch, one for data loads and stores) and one backing memory. The instruction side and the data side each have a small direct-mapped cache. Both caches answer hits in the same cycle with no memory traffic. One address space holds code and data together, so a word fetched as an instruction and the same word loaded as data come from the same memory location.

A read miss on either side starts a four-word line refill on the single memory port. When both sides miss together, the two refills run one after the other, instruction first. A side that is not refilling keeps serving its own hits during the other side's refill. Data stores are write-through without allocation. A store also removes any instruction-cache line that holds the stored address, so self-modifying code and inserted breakpoints take effect on the next fetch.

Addresses are word addresses, 10 bits wide by default. Bits [1:0] select the word within a line, bits [3:2] select the line, and the upper bits form the tag. The memory returns read data one cycle after a read request and completes a write in the cycle it is presented. A core must hold its request and address stable while its ready output is low.

Top module: `split_cache_arb`

## Requirements
- R1: Reset clears every valid bit in both caches. While reset is active, and afterwards with no request present, no memory request is made and both ready outputs are low. The first access to any line after reset is a miss.
- R2: When both sides request addresses held in their caches, both ready outputs are high in the same cycle as the request, with the cached words, and no memory request is made.
- R3: While one side is refilling, a hit on the other side is answered in the cycle it is presented, with no added delay.
- R4: A refill issues four memory reads in consecutive cycles. The reads go to ascending word addresses, starting at the line base (the address with bits [1:0] equal to 00).
- R5: On a read miss with no other refill pending, ready stays low and then goes high 6 cycles after the request appears, with the memory word at the requested address.
- R6: When both sides miss in the same cycle, the instruction line is read first (the first four memory reads), then the data line. Instruction ready returns after 6 cycles and data ready after 12.
- R7: A data store is a single memory write (write enable high, address and data taken from the data bus). It is acknowledged in the same cycle when no instruction refill is pending. A store that hits the data cache updates the cached word. A store that misses does not allocate a line, so a later load of that address misses.
- R8: A data store to an address held in the instruction cache invalidates that line. The next fetch of that address misses and returns the stored value.
- R9: A data store presented together with an instruction miss waits until the instruction refill finishes. Both sides are then acknowledged after 6 cycles.
- R10: Both sides see one address space. A load of an address reads the same memory word as a fetch of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_req_i | input | 1 | Instruction fetch request |
| if_addr_i | input | ADDR_W | Fetch word address |
| if_rdata_o | output | DATA_W | Fetched word, valid with if_ready_o |
| if_ready_o | output | 1 | Fetch completed this cycle |
| dc_req_i | input | 1 | Data access request |
| dc_we_i | input | 1 | 1 = store, 0 = load |
| dc_addr_i | input | ADDR_W | Data word address |
| dc_wdata_i | input | DATA_W | Store data |
| dc_rdata_o | output | DATA_W | Loaded word, valid with dc_ready_o on a load |
| dc_ready_o | output | 1 | Data access completed this cycle |
| mem_req_o | output | 1 | Backing-memory request |
| mem_we_o | output | 1 | Backing-memory write enable |
| mem_addr_o | output | ADDR_W | Backing-memory word address |
| mem_wdata_o | output | DATA_W | Backing-memory write data |
| mem_rdata_i | input | DATA_W | Backing-memory read data, one cycle after a read |

## Verification
The main function is exercised with every combination of the two sides: both hit, only one side misses, both miss at once, and one side alone. Each case is checked for its latency per side and for the number of memory reads it triggers. These measurements tell a parallel hit apart from a serialized refill and show whether the instruction-first order holds. The read addresses logged during the double miss show the line order and the ascending word order. Separate store cases target a hit, a miss, an address held by the instruction cache, and a store that collides with an instruction miss. Each is followed by a read-back that shows whether the caches were updated, left unallocated or invalidated.

// File: rtl/scarb_pkg.sv
package scarb_pkg;
  typedef enum logic [1:0] {ARB_IDLE, ARB_FILL, ARB_LAST} arb_state_e;
  typedef enum logic {SIDE_I = 1'b0, SIDE_D = 1'b1} side_e;
endpackage

// File: rtl/cache_array.sv
module cache_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              fill_we_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              fill_last_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inv_en_i,
  input  logic [ADDR_W-1:0] inv_addr_i
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [DATA_W-1:0] data_q [LINES][WORDS];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q;

  logic [IDX_W-1:0] lk_idx, f_idx, w_idx, v_idx;
  logic [OFF_W-1:0] lk_off, f_off, w_off;
  logic [TAG_W-1:0] lk_tag, f_tag, w_tag, v_tag;
  logic             wr_hit, inv_hit;

  assign lk_idx = lk_addr_i[OFF_W +: IDX_W];
  assign lk_off = lk_addr_i[OFF_W-1:0];
  assign lk_tag = lk_addr_i[ADDR_W-1 -: TAG_W];
  assign f_idx  = fill_addr_i[OFF_W +: IDX_W];
  assign f_off  = fill_addr_i[OFF_W-1:0];
  assign f_tag  = fill_addr_i[ADDR_W-1 -: TAG_W];
  assign w_idx  = wr_addr_i[OFF_W +: IDX_W];
  assign w_off  = wr_addr_i[OFF_W-1:0];
  assign w_tag  = wr_addr_i[ADDR_W-1 -: TAG_W];
  assign v_idx  = inv_addr_i[OFF_W +: IDX_W];
  assign v_tag  = inv_addr_i[ADDR_W-1 -: TAG_W];

  assign hit_o   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign rdata_o = data_q[lk_idx][lk_off];
  assign wr_hit  = valid_q[w_idx] && (tag_q[w_idx] == w_tag);
  assign inv_hit = valid_q[v_idx] && (tag_q[v_idx] == v_tag);

  always_ff @(posedge clk_i) begin
    if (fill_we_i)                data_q[f_idx][f_off] <= fill_data_i;
    else if (wr_en_i && wr_hit)   data_q[w_idx][w_off] <= wr_data_i;
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[l] <= 1'b0;
        tag_q[l]   <= '0;
      end else if (fill_we_i && f_idx == IDX_W'(l)) begin
        // line is unusable while it is part-way refilled
        valid_q[l] <= fill_last_i;
        if (fill_last_i) tag_q[l] <= f_tag;
      end else if (inv_en_i && inv_hit && v_idx == IDX_W'(l)) begin
        valid_q[l] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/refill_arb.sv
module refill_arb
  import scarb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              i_miss_i,
  input  logic [ADDR_W-1:0] i_addr_i,
  input  logic              d_miss_i,
  input  logic [ADDR_W-1:0] d_addr_i,
  input  logic              wr_req_i,
  output logic              wr_gnt_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              cap_vld_o,
  output side_e             cap_side_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic              cap_last_o
);
  localparam int LB_W = ADDR_W - OFF_W;

  arb_state_e       state_q;
  side_e            side_q;
  logic [LB_W-1:0]  base_q;
  logic [OFF_W-1:0] cnt_q, cap_off_q;
  logic             cap_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ARB_IDLE;
      side_q    <= SIDE_I;
      base_q    <= '0;
      cnt_q     <= '0;
      cap_vld_q <= 1'b0;
      cap_off_q <= '0;
    end else begin
      cap_vld_q <= (state_q == ARB_FILL);
      cap_off_q <= cnt_q;
      unique case (state_q)
        ARB_IDLE: begin
          cnt_q <= '0;
          if (i_miss_i) begin
            side_q  <= SIDE_I;
            base_q  <= i_addr_i[ADDR_W-1:OFF_W];
            state_q <= ARB_FILL;
          end else if (d_miss_i) begin
            side_q  <= SIDE_D;
            base_q  <= d_addr_i[ADDR_W-1:OFF_W];
            state_q <= ARB_FILL;
          end
        end
        ARB_FILL: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '1) state_q <= ARB_LAST;
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign wr_gnt_o   = (state_q == ARB_IDLE) && !i_miss_i && wr_req_i;
  assign rd_o       = (state_q == ARB_FILL);
  assign rd_addr_o  = {base_q, cnt_q};
  assign cap_vld_o  = cap_vld_q;
  assign cap_side_o = side_q;
  assign cap_addr_o = {base_q, cap_off_q};
  assign cap_last_o = cap_vld_q && (cap_off_q == '1);
endmodule

// File: rtl/split_cache_arb.sv
module split_cache_arb
  import scarb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              if_req_i,
  input  logic [ADDR_W-1:0] if_addr_i,
  output logic [DATA_W-1:0] if_rdata_o,
  output logic              if_ready_o,
  input  logic              dc_req_i,
  input  logic              dc_we_i,
  input  logic [ADDR_W-1:0] dc_addr_i,
  input  logic [DATA_W-1:0] dc_wdata_i,
  output logic [DATA_W-1:0] dc_rdata_o,
  output logic              dc_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              i_hit, d_hit, i_miss, d_miss, wr_req, wr_gnt;
  logic              rd, cap_vld, cap_last;
  side_e             cap_side;
  logic [ADDR_W-1:0] rd_addr, cap_addr;

  assign i_miss = if_req_i && !i_hit;
  assign d_miss = dc_req_i && !dc_we_i && !d_hit;
  assign wr_req = dc_req_i && dc_we_i;

  cache_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_icache (
    .clk_i, .rst_ni,
    .lk_addr_i   (if_addr_i),
    .hit_o       (i_hit),
    .rdata_o     (if_rdata_o),
    .fill_we_i   (cap_vld && cap_side == SIDE_I),
    .fill_addr_i (cap_addr),
    .fill_data_i (mem_rdata_i),
    .fill_last_i (cap_last),
    .wr_en_i     (1'b0),
    .wr_addr_i   ('0),
    .wr_data_i   ('0),
    .inv_en_i    (wr_gnt),
    .inv_addr_i  (dc_addr_i)
  );

  cache_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_dcache (
    .clk_i, .rst_ni,
    .lk_addr_i   (dc_addr_i),
    .hit_o       (d_hit),
    .rdata_o     (dc_rdata_o),
    .fill_we_i   (cap_vld && cap_side == SIDE_D),
    .fill_addr_i (cap_addr),
    .fill_data_i (mem_rdata_i),
    .fill_last_i (cap_last),
    .wr_en_i     (wr_gnt),
    .wr_addr_i   (dc_addr_i),
    .wr_data_i   (dc_wdata_i),
    .inv_en_i    (1'b0),
    .inv_addr_i  ('0)
  );

  refill_arb #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_arb (
    .clk_i, .rst_ni,
    .i_miss_i   (i_miss),
    .i_addr_i   (if_addr_i),
    .d_miss_i   (d_miss),
    .d_addr_i   (dc_addr_i),
    .wr_req_i   (wr_req),
    .wr_gnt_o   (wr_gnt),
    .rd_o       (rd),
    .rd_addr_o  (rd_addr),
    .cap_vld_o  (cap_vld),
    .cap_side_o (cap_side),
    .cap_addr_o (cap_addr),
    .cap_last_o (cap_last)
  );

  assign if_ready_o  = if_req_i && i_hit;
  assign dc_ready_o  = dc_req_i && (dc_we_i ? wr_gnt : d_hit);
  assign mem_req_o   = rd || wr_gnt;
  assign mem_we_o    = wr_gnt;
  assign mem_addr_o  = wr_gnt ? dc_addr_i : rd_addr;
  assign mem_wdata_o = dc_wdata_i;
endmodule

// File: rtl/split_cache_arb_chk.sv
module split_cache_arb_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              if_req_i,
  input logic [ADDR_W-1:0] if_addr_i,
  input logic [DATA_W-1:0] if_rdata_o,
  input logic              if_ready_o,
  input logic              dc_req_i,
  input logic              dc_we_i,
  input logic [ADDR_W-1:0] dc_addr_i,
  input logic [DATA_W-1:0] dc_wdata_i,
  input logic [DATA_W-1:0] dc_rdata_o,
  input logic              dc_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] mem_rdata_i
);
  logic mem_rd;
  assign mem_rd = mem_req_o && !mem_we_o;

  assert_no_req_in_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !mem_req_o);

  assert_ready_needs_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_ready_o |-> if_req_i) and (dc_ready_o |-> dc_req_i));

  assert_hits_no_mem_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_req_i && if_ready_o && dc_req_i && !dc_we_i && dc_ready_o |-> !mem_req_o);

  assert_burst_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd && !$past(mem_rd) |-> mem_addr_o[OFF_W-1:0] == '0);

  assert_burst_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd && (mem_addr_o[OFF_W-1:0] != '1)
    |=> mem_rd && (mem_addr_o == $past(mem_addr_o) + 1'b1));

  assert_store_path_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> dc_req_i && dc_we_i && dc_ready_o
                             && mem_addr_o == dc_addr_i && mem_wdata_o == dc_wdata_i);

  assert_store_waits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_req_i && !if_ready_o && dc_req_i && dc_we_i |-> !dc_ready_o);
endmodule

bind split_cache_arb split_cache_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/split_cache_arb_bench.sv
`timescale 1ns/1ps
module split_cache_arb_bench;
  localparam int AW = 10;
  localparam int DW = 32;

  typedef struct packed {
    logic          ir;
    logic [AW-1:0] ia;
    logic          dr;
    logic [AW-1:0] da;
    logic [4:0]    il;
    logic [4:0]    dl;
    logic [3:0]    nrd;
  } vec_t;

  // fetch/load pairs: latency per side (cycles) and memory reads expected
  localparam vec_t VECS [7] = '{
    '{1'b1, 10'h010, 1'b0, 10'h000, 5'd6,  5'd0,  4'd4},  // R1 R5
    '{1'b0, 10'h000, 1'b1, 10'h104, 5'd0,  5'd6,  4'd4},  // R1 R5
    '{1'b1, 10'h012, 1'b1, 10'h107, 5'd0,  5'd0,  4'd0},  // R2
    '{1'b1, 10'h024, 1'b1, 10'h105, 5'd6,  5'd0,  4'd4},  // R3
    '{1'b1, 10'h038, 1'b1, 10'h20C, 5'd6,  5'd12, 4'd8},  // R6
    '{1'b1, 10'h013, 1'b1, 10'h011, 5'd0,  5'd6,  4'd4},  // R3 R10
    '{1'b1, 10'h039, 1'b1, 10'h20D, 5'd0,  5'd0,  4'd0}   // R2
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic          if_req_i = 1'b0, if_ready_o;
  logic [AW-1:0] if_addr_i = '0;
  logic [DW-1:0] if_rdata_o;
  logic          dc_req_i = 1'b0, dc_we_i = 1'b0, dc_ready_o;
  logic [AW-1:0] dc_addr_i = '0;
  logic [DW-1:0] dc_wdata_i = '0, dc_rdata_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i;

  split_cache_arb u_split_cache_arb (
    .clk_i(clk), .rst_ni,
    .if_req_i, .if_addr_i, .if_rdata_o, .if_ready_o,
    .dc_req_i, .dc_we_i, .dc_addr_i, .dc_wdata_i, .dc_rdata_o, .dc_ready_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i
  );

  logic [DW-1:0] mem [1 << AW];
  logic [AW-1:0] rd_log [16];
  int rd_n = 0;
  int wr_n = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
    return 32'hC0DE0000 | 32'(a);
  endfunction

  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        mem[mem_addr_o] <= mem_wdata_o;
        wr_n = wr_n + 1;
      end else begin
        mem_rdata_i <= mem[mem_addr_o];
        if (rd_n < 16) rd_log[rd_n] = mem_addr_o;
        rd_n = rd_n + 1;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic access(input logic ir, input logic [AW-1:0] ia,
                        input logic dr, input logic dwe, input logic [AW-1:0] da,
                        input logic [DW-1:0] wd,
                        output int il, output logic [DW-1:0] idat,
                        output int dl, output logic [DW-1:0] ddat);
    bit idone, ddone;
    int n;
    @(negedge clk);
    if_req_i = ir; if_addr_i = ia;
    dc_req_i = dr; dc_we_i = dwe; dc_addr_i = da; dc_wdata_i = wd;
    rd_n = 0; wr_n = 0;
    idone = !ir; ddone = !dr; il = -1; dl = -1; idat = '0; ddat = '0; n = 0;
    while (!(idone && ddone) && n < 60) begin
      #1;
      if (!idone && if_ready_o) begin il = n; idat = if_rdata_o; idone = 1; end
      if (!ddone && dc_ready_o) begin dl = n; ddat = dc_rdata_o; ddone = 1; end
      @(posedge clk); #1;
      if (idone) if_req_i = 1'b0;
      if (ddone) begin dc_req_i = 1'b0; dc_we_i = 1'b0; end
      @(negedge clk);
      n++;
    end
    if_req_i = 1'b0; dc_req_i = 1'b0; dc_we_i = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int il, dl;
    logic [DW-1:0] id, dd;
    for (int a = 0; a < (1 << AW); a++) mem[a] = init_word(AW'(a));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 mem_req in reset", 32'(mem_req_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 mem_req idle", 32'(mem_req_o), 0);
    chk("R1 ready idle", 32'({if_ready_o, dc_ready_o}), 0);

    // table of read patterns
    for (int v = 0; v < 7; v++) begin
      access(VECS[v].ir, VECS[v].ia, VECS[v].dr, 1'b0, VECS[v].da, '0, il, id, dl, dd);
      if (VECS[v].ir) begin
        chk($sformatf("R5 vec%0d fetch latency", v), 32'(il), 32'(VECS[v].il));
        chk($sformatf("R10 vec%0d fetch data", v), id, mem[VECS[v].ia]);
      end
      if (VECS[v].dr) begin
        chk($sformatf("R3 vec%0d load latency", v), 32'(dl), 32'(VECS[v].dl));
        chk($sformatf("R10 vec%0d load data", v), dd, mem[VECS[v].da]);
      end
      chk($sformatf("R2 vec%0d memory reads", v), 32'(rd_n), 32'(VECS[v].nrd));
      if (v == 4) begin
        // R6 R4: instruction line first, ascending words
        for (int k = 0; k < 4; k++) begin
          chk("R6 first line order", 32'(rd_log[k]), 32'(10'h038 + k));
          chk("R4 second line order", 32'(rd_log[k+4]), 32'(10'h20C + k));
        end
      end
    end

    // R7: store hit, write-through, same-cycle ack
    access(0, '0, 1, 1, 10'h105, 32'hDEAD0105, il, id, dl, dd);
    chk("R7 store ack latency", 32'(dl), 0);
    chk("R7 store writes", 32'(wr_n), 1);
    chk("R7 memory updated", mem[10'h105], 32'hDEAD0105);
    access(0, '0, 1, 0, 10'h105, '0, il, id, dl, dd);
    chk("R7 hit updated latency", 32'(dl), 0);
    chk("R7 hit updated data", dd, 32'hDEAD0105);

    // R7: store miss does not allocate
    access(0, '0, 1, 1, 10'h300, 32'h00AA0300, il, id, dl, dd);
    chk("R7 store miss ack", 32'(dl), 0);
    access(0, '0, 1, 0, 10'h300, '0, il, id, dl, dd);
    chk("R7 no allocate latency", 32'(dl), 6);
    chk("R7 no allocate data", dd, 32'h00AA0300);

    // R8: store into a line held by the instruction cache
    access(0, '0, 1, 1, 10'h012, 32'hBEEF0012, il, id, dl, dd);
    chk("R8 store ack", 32'(dl), 0);
    access(1, 10'h012, 0, 0, '0, '0, il, id, dl, dd);
    chk("R8 refetch misses", 32'(il), 6);
    chk("R8 refetch new data", id, 32'hBEEF0012);

    // R9: store collides with an instruction miss
    access(1, 10'h05C, 1, 1, 10'h106, 32'h0B0B0106, il, id, dl, dd);
    chk("R9 fetch latency", 32'(il), 6);
    chk("R9 store waits", 32'(dl), 6);
    chk("R9 fetch data", id, init_word(10'h05C));
    chk("R9 memory updated", mem[10'h106], 32'h0B0B0106);
    access(0, '0, 1, 0, 10'h106, '0, il, id, dl, dd);
    chk("R9 load after store", dd, 32'h0B0B0106);

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule